// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block collects interrupt events from a set of raw request lines and holds them in a pending register. Each line is either level-sensitive (active high) or edge-sensitive, and an edge-sensitive line can react to either its rising or its falling transition. Raw lines are first brought into the clock domain by a multi-flop synchronizer. A single stored copy of the synchronized value is used for edge detection.

Software can load pending bits directly by writing a bit vector. It can drop one pending bit by writing that bit's index. A downstream resolver drops a bit by strobing an accept with the index of the line it has taken into service. The pending vector is presented unmasked. Arbitration and masking happen further down the chain. If a hardware or software set meets a clear on the same bit in the same cycle, the set takes effect, so no event is dropped.

Top module: `irq_pend_capture`

## Requirements
- R1: While `rst_ni` is low, `pend_o` is all zero, the mode register reads `MODE_RST` and the polarity register reads `POL_RST`.
- R2: A line whose mode bit is 0 (level) and that is held high sets its pending bit on the third rising clock edge after the line rises (two synchronizer flops, then the pending register).
- R3: In level mode the set is repeated on every cycle that the synchronized line is high. An accept or a clear-vector write for that bit while the line stays high leaves the bit set.
- R4: A line whose mode bit is 1 (edge) and whose polarity bit is 1 sets its pending bit on a 0-to-1 transition. A high pulse of one clock cycle is enough, and the bit appears two edges after the edge that samples the pulse. A 1-to-0 transition has no effect.
- R5: A line in edge mode whose polarity bit is 0 sets its pending bit on a 1-to-0 transition. A 0-to-1 transition has no effect.
- R6: Once set by an edge, a pending bit stays set after the line returns to its idle level, until it is cleared.
- R7: A write to address 2 (software set) sets, at the write's clock edge, the pending bit for every 1 in `wr_data_i`. Bits written as 0 are left unchanged.
- R8: A write to address 3 (clear vector) clears, at the write's clock edge, the single pending bit whose index is in `wr_data_i[IDX_W-1:0]`. All other bits are left unchanged.
- R9: `ack_i` high with index `ack_idx_i` clears that pending bit at the clock edge when no set hits the same bit.
- R10: When a set (hardware or software) and a clear (accept or clear vector) target the same bit in the same cycle, the bit ends up set.
- R11: `rd_data_o` is a combinational readback selected by `rd_addr_i`: 0 gives the mode register (1 = edge), 1 gives the polarity register (1 = rising), 2 gives the pending vector, and 3 gives zero. Addresses 0 and 1 are written through the same write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Raw request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 mode, 1 polarity, 2 software set, 3 clear vector) |
| wr_data_i | input | N_SRC | Write data |
| rd_addr_i | input | 2 | Readback address |
| rd_data_o | output | N_SRC | Readback data |
| ack_i | input | 1 | Accept strobe from the resolver |
| ack_idx_i | input | IDX_W | Index of the accepted line |
| pend_o | output | N_SRC | Pending request vector, unmasked |

## Verification
The bench builds the block with eight lines, two synchronizer stages and non-uniform reset values for mode and polarity. With eight lines, every line index can be swept in level mode, rising-edge mode and falling-edge mode. All 256 software-set patterns can also be applied, each followed by a bit-by-bit clear-vector walk. The small width also makes it practical to line up a synchronized edge with an accept on the same cycle, which is the set-versus-clear race.

// File: rtl/irq_cap_pkg.sv
`timescale 1ns/1ps
package irq_cap_pkg;
  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_POL    = 2'd1,
    REG_SWSET  = 2'd2,
    REG_CLRVEC = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int N_SRC  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] async_i,
  output logic [N_SRC-1:0] sync_o
);
  logic [N_SRC-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
`timescale 1ns/1ps
module irq_detect #(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] sync_i,
  input  logic [N_SRC-1:0] edge_mode_i,
  input  logic [N_SRC-1:0] rise_i,
  output logic [N_SRC-1:0] set_o
);
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_det
    logic up, dn;
    assign up = sync_i[g] & ~prev_q[g];
    assign dn = ~sync_i[g] & prev_q[g];
    assign set_o[g] = edge_mode_i[g] ? (rise_i[g] ? up : dn) : sync_i[g];
  end

  // same-polarity edges cannot occur on two consecutive cycles
  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((set_o & $past(set_o) & edge_mode_i & $past(edge_mode_i)
               & ~(rise_i ^ $past(rise_i))) == '0)); // R4
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_cap_pkg::*;
#(
  parameter int               N_SRC    = 16,
  parameter int               IDX_W    = 4,
  parameter logic [N_SRC-1:0] MODE_RST = '0,
  parameter logic [N_SRC-1:0] POL_RST  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] mode_o,
  output logic [N_SRC-1:0] pol_o,
  output logic [N_SRC-1:0] sw_set_o,
  output logic [N_SRC-1:0] clr_vec_o
);
  logic [N_SRC-1:0] mode_q, pol_q;
  logic [IDX_W-1:0] clr_idx;
  logic             clr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      pol_q  <= POL_RST;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_MODE) mode_q <= wr_data_i;
      if (wr_addr_i == REG_POL)  pol_q  <= wr_data_i;
    end
  end

  assign mode_o   = mode_q;
  assign pol_o    = pol_q;
  assign sw_set_o = (wr_en_i && wr_addr_i == REG_SWSET) ? wr_data_i : '0;
  assign clr_idx  = wr_data_i[IDX_W-1:0];
  assign clr_hit  = wr_en_i && (wr_addr_i == REG_CLRVEC);

  for (genvar g = 0; g < N_SRC; g++) begin : g_clr
    assign clr_vec_o[g] = clr_hit && (clr_idx == IDX_W'(g));
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_vec_o)); // R8
endmodule

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg #(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i; // set dominates
  end

  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set_i)) == $past(set_i))); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0)); // R7
  AST_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0)); // R6
endmodule

// File: rtl/irq_pend_capture.sv
`timescale 1ns/1ps
module irq_pend_capture
  import irq_cap_pkg::*;
#(
  parameter int               N_SRC       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0] MODE_RST    = '0,
  parameter logic [N_SRC-1:0] POL_RST     = '1,
  localparam int              IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [N_SRC-1:0] rd_data_o,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] sync, hw_set, mode, pol, sw_set, clr_vec, ack_vec, pend;

  irq_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .async_i(irq_i), .sync_o(sync)
  );

  irq_cfg_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W), .MODE_RST(MODE_RST), .POL_RST(POL_RST)) cfg_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .pol_o(pol), .sw_set_o(sw_set), .clr_vec_o(clr_vec)
  );

  irq_detect #(.N_SRC(N_SRC)) det_i (
    .clk_i, .rst_ni, .sync_i(sync), .edge_mode_i(mode), .rise_i(pol), .set_o(hw_set)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign ack_vec[g] = ack_i && (ack_idx_i == IDX_W'(g));
  end

  irq_pend_reg #(.N_SRC(N_SRC)) pend_i (
    .clk_i, .rst_ni, .set_i(hw_set | sw_set), .clr_i(ack_vec | clr_vec), .pend_o(pend)
  );

  assign pend_o = pend;

  always_comb begin
    unique case (rd_addr_i)
      REG_MODE:  rd_data_o = mode;
      REG_POL:   rd_data_o = pol;
      REG_SWSET: rd_data_o = pend;
      default:   rd_data_o = '0;
    endcase
  end

  AST_LEVEL_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sync & ~mode) & ~pend_o) == '0)); // R3
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hw_set[ack_idx_i] && !sw_set[ack_idx_i]) |=> !pend_o[$past(ack_idx_i)]); // R9
endmodule

// File: tb/irq_pend_capture_tb_top.sv
`timescale 1ns/1ps
module irq_pend_capture_tb_top;
  import irq_cap_pkg::*;

  localparam int         N      = 8;
  localparam int         IW     = 3;
  localparam logic [7:0] MODE_R = 8'h0F;
  localparam logic [7:0] POL_R  = 8'h55;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [N-1:0]  rd_data;
  logic          ack = 1'b0;
  logic [IW-1:0] ack_idx = '0;
  logic [N-1:0]  pend;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  irq_pend_capture #(.N_SRC(N), .SYNC_STAGES(2), .MODE_RST(MODE_R), .POL_RST(POL_R)) dut_i (
    .clk_i(clk), .rst_ni, .irq_i(irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ack_i(ack), .ack_idx_i(ack_idx), .pend_o(pend)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic do_ack(input int i);
    ack = 1'b1; ack_idx = IW'(i);
    tick();
    ack = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 pend at reset", pend, '0);
    rd_chk("R1 mode reset", REG_MODE, MODE_R);
    rd_chk("R1 pol reset", REG_POL, POL_R);
    rst_ni = 1'b1;
    tick();

    // R11 readback of written config
    wr(REG_MODE, 8'hA5);
    rd_chk("R11 mode readback", REG_MODE, 8'hA5);
    wr(REG_POL, 8'h3C);
    rd_chk("R11 pol readback", REG_POL, 8'h3C);
    rd_chk("R11 addr3 zero", REG_CLRVEC, '0);

    // R2/R3 level mode sweep
    wr(REG_MODE, '0);
    for (int i = 0; i < N; i++) begin
      irq = N'(1 << i);
      tick(); tick();
      chk("R2 level not yet", pend, '0);
      tick();
      chk("R2 level latency", pend, N'(1 << i));
      do_ack(i);
      chk("R3 accept while high", pend, N'(1 << i));
      wr(REG_CLRVEC, N'(i));
      chk("R3 clear while high", pend, N'(1 << i));
      irq = '0;
      repeat (3) tick();
      wr(REG_CLRVEC, N'(i));
      chk("R8 clear after release", pend, '0);
    end
    rd_chk("R11 pend readback", REG_SWSET, '0);

    // R4/R6/R9 rising edge sweep, single-cycle pulses
    wr(REG_POL, '1);
    wr(REG_MODE, '1);
    rd_chk("R11 mode all edge", REG_MODE, '1);
    for (int i = 0; i < N; i++) begin
      irq = N'(1 << i);
      tick();
      irq = '0;
      tick();
      chk("R4 rise not yet", pend, '0);
      tick();
      chk("R4 rise pulse captured", pend, N'(1 << i));
      repeat (3) tick();
      chk("R6 edge persists", pend, N'(1 << i));
      do_ack(i);
      chk("R9 accept clears", pend, '0);
    end
    irq = '1;
    repeat (3) tick();
    chk("R4 all rising", pend, '1);
    for (int i = 0; i < N; i++) do_ack(i);
    chk("R9 accept all", pend, '0);
    irq = '0;
    repeat (4) tick();
    chk("R4 falling ignored", pend, '0);

    // R5 falling edge sweep
    wr(REG_POL, '0);
    irq = '1;
    repeat (4) tick();
    chk("R5 rising ignored", pend, '0);
    for (int i = 0; i < N; i++) begin
      irq = ~N'(1 << i);
      tick();
      irq = '1;
      tick();
      chk("R5 fall not yet", pend, '0);
      tick();
      chk("R5 fall captured", pend, N'(1 << i));
      do_ack(i);
      chk("R9 accept after fall", pend, '0);
    end

    // R7/R8 exhaustive software set with clear-vector walk (lines steady high)
    for (int v = 0; v < 256; v++) begin
      wr(REG_SWSET, N'(v));
      chk("R7 software set", pend, N'(v));
      for (int j = 0; j < N; j++) begin
        wr(REG_CLRVEC, N'(j));
        chk("R8 clear vector walk", pend, N'(v & ~((1 << (j + 1)) - 1)));
      end
    end

    // R10 set beats clear
    wr(REG_POL, '1);
    irq = '0;
    repeat (3) tick();
    chk("R10 setup idle", pend, '0);
    wr(REG_SWSET, 8'h04);
    irq = 8'h04;
    tick();
    irq = '0;
    tick();
    do_ack(2);
    chk("R10 edge beats accept", pend, 8'h04);
    do_ack(2);
    chk("R10 then accept clears", pend, '0);
    ack = 1'b1; ack_idx = 3'd5;
    wr(REG_SWSET, 8'h20);
    ack = 1'b0;
    chk("R10 software set beats accept", pend, 8'h20);
    wr(REG_SWSET, 8'h08);
    chk("R7 accumulate", pend, 8'h28);
    ack = 1'b1; ack_idx = 3'd5;
    wr(REG_CLRVEC, 8'd3);
    ack = 1'b0;
    chk("R9 R8 simultaneous clears", pend, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule